// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block chooses which pending interrupt a processor core should take next. It forms a pending mask from two sources. One is an external bus of level interrupts. The other is a software-interrupt register that carries two timer-match flags. The block then compares the mask with the core's current interrupt level, the global enable, and the trap that is already in progress. The result is a registered hard-interrupt request and a registered trap type.

A single-entry receive latch for vectored interrupts sits beside the level arbiter. A rising edge on the vectored input claims the latch and presents the vectored trap type. It also loads three vector data words. While the latch is busy, level arbitration is frozen. A falling edge on the vectored input releases the latch and withdraws the request.

Every decision is made once per clock. The request, the trap type and the data words are all register outputs, so each one changes on the clock edge that follows the input it responds to.

Top module: `lvl_irq_resolver`

## Requirements
- R1: A synchronous active-high reset forces irq_req to 0, trap_idx to 0 and all three vector words to 0, and leaves the latch free: a vectored rising edge right after reset is accepted.
- R2: The pending mask is ext_lvl OR soft_int[15:0], with soft_int bit 0 removed. If soft_int bit 0 (tick match) or bit 16 (system-tick match) is set, mask bit 14 is forced to 1.
- R3: When the mask, read as an unsigned number, is below 2 << cur_pil, the next cycle shows irq_req = 0 and trap_idx = 0. This includes cur_pil = 15, and a mask whose only set bit is bit 0.
- R4: With the enable high and the mask eligible, the highest set mask bit above cur_pil wins, and trap_idx becomes 0x40 | level.
- R5: When trap_lvl is nonzero, and cur_tt is an external-interrupt type ((cur_tt & 0x1F0) == 0x40) that is numerically greater than the new type, the outputs keep their previous values. Otherwise the new type is taken.
- R6: irq_req is raised and trap_idx is updated only when the selected type differs from the stored one. An unchanged selection leaves both outputs steady.
- R7: When int_en is low (and the mask is eligible), irq_req drops to 0 and trap_idx clears to 0.
- R8: A rising edge on vec_in while the latch is free sets irq_req = 1 and trap_idx = 0x60. It also loads vec_w0 = (0x1F << 6) | vec_irq, and vec_w1 = vec_w2 = 0.
- R9: While the latch is busy, level inputs have no effect: trap_idx and irq_req hold.
- R10: A falling edge on vec_in while the latch is busy frees the latch and drops irq_req, with trap_idx kept. Level arbitration resumes on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External level interrupts; bit n is level n |
| soft_int | input | 17 | Software interrupts: bit 0 tick match, bits 15:1 levels, bit 16 system-tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type of the trap in progress |
| vec_in | input | 1 | Vectored interrupt line |
| vec_irq | input | 6 | Vectored interrupt number |
| irq_req | output | 1 | Hard-interrupt request |
| trap_idx | output | 9 | Selected trap type |
| vec_w0 | output | 64 | Vector data word 0 |
| vec_w1 | output | 64 | Vector data word 1 |
| vec_w2 | output | 64 | Vector data word 2 |

## Verification
The hardest state to reach from the ports is the nesting-suppression case. It needs a nonzero trap level, an in-progress type inside the external-interrupt class that ranks above the new candidate, and a stored index that stays visible afterwards. The stimulus table builds this over consecutive rows. It sets up a known index, then presents a lower candidate, first with a higher in-progress type, then with a lower one, then with a non-interrupt type. This shows that the outputs hold only when all three conditions meet. A directed sequence then claims the vector latch while a level interrupt is pending, changes the level inputs while the latch is busy, and releases it. The resumed arbitration must then replace the retained vector type.

// File: rtl/lvl_irq_resolver.sv
module lvl_irq_resolver #(
  parameter int TT_W   = 9,
  parameter int TL_W   = 3,
  parameter int IRQ_W  = 6,
  parameter int WORD_W = 64,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040,
  parameter logic [TT_W-1:0] VEC_TT   = 9'h060
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       ext_lvl,
  input  logic [16:0]       soft_int,
  input  logic [3:0]        cur_pil,
  input  logic              int_en,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TT_W-1:0]   cur_tt,
  input  logic              vec_in,
  input  logic [IRQ_W-1:0]  vec_irq,
  output logic              irq_req,
  output logic [TT_W-1:0]   trap_idx,
  output logic [WORD_W-1:0] vec_w0,
  output logic [WORD_W-1:0] vec_w1,
  output logic [WORD_W-1:0] vec_w2
);
  localparam logic [TT_W-1:0] CLASS_MASK = TT_W'(9'h1F0);
  localparam logic [WORD_W-1:0] W0_TAG = WORD_W'(32'h1F) << 6;

  logic        busy_q, vec_prev_q;
  logic [15:0] pend;
  logic        timer_hit, below, nested;
  logic [3:0]  win;
  logic [TT_W-1:0] cand;

  assign timer_hit = soft_int[0] | soft_int[16];
  assign pend      = (ext_lvl | {soft_int[15:1], 1'b0}) | {1'b0, timer_hit, 14'd0};
  assign below     = {1'b0, pend} < (17'd2 << cur_pil);

  always_comb begin
    win = 4'd0;
    for (int i = 1; i < 16; i++)
      if (pend[i] && (4'(i) > cur_pil)) win = 4'(i);
  end

  assign cand   = EXT_BASE | TT_W'(win);
  assign nested = (trap_lvl != '0) && (cur_tt > cand) && ((cur_tt & CLASS_MASK) == EXT_BASE);

  wire vec_rise = vec_in & ~vec_prev_q;
  wire vec_fall = ~vec_in & vec_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      trap_idx   <= '0;
      busy_q     <= 1'b0;
      vec_prev_q <= 1'b0;
      vec_w0     <= '0;
      vec_w1     <= '0;
      vec_w2     <= '0;
    end else begin
      vec_prev_q <= vec_in;
      if (vec_rise && !busy_q) begin
        busy_q   <= 1'b1;
        irq_req  <= 1'b1;
        trap_idx <= VEC_TT;
        vec_w0   <= W0_TAG | WORD_W'(vec_irq);
        vec_w1   <= '0;
        vec_w2   <= '0;
      end else if (vec_fall && busy_q) begin
        busy_q  <= 1'b0;
        irq_req <= 1'b0;
      end else if (!busy_q) begin
        if (below || !int_en) begin
          irq_req  <= 1'b0;
          trap_idx <= '0;
        end else if (!nested && cand != trap_idx) begin
          irq_req  <= 1'b1;
          trap_idx <= cand;
        end
      end
    end
  end
endmodule

module lvl_irq_resolver_chk #(
  parameter int TT_W   = 9,
  parameter int WORD_W = 64,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040,
  parameter logic [TT_W-1:0] VEC_TT   = 9'h060
) (
  input logic              clk,
  input logic              rst,
  input logic              vec_in,
  input logic              int_en,
  input logic              irq_req,
  input logic [TT_W-1:0]   trap_idx,
  input logic [WORD_W-1:0] vec_w1,
  input logic [WORD_W-1:0] vec_w2,
  input logic              busy_q,
  input logic              vec_prev_q
);
  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (vec_in && !vec_prev_q && !busy_q) |=> (irq_req && trap_idx == VEC_TT && vec_w1 == '0 && vec_w2 == '0)); // R8
  AST_VEC_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!vec_in && vec_prev_q && busy_q) |=> !irq_req); // R10
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && vec_in && vec_prev_q) |=> ($stable(trap_idx) && $stable(irq_req))); // R9
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !vec_in && !vec_prev_q && !int_en) |=> (!irq_req && trap_idx == '0)); // R7
  AST_RAISE_TYPE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (trap_idx == VEC_TT || trap_idx[TT_W-1:4] == EXT_BASE[TT_W-1:4])); // R4
endmodule

bind lvl_irq_resolver lvl_irq_resolver_chk #(
  .TT_W(TT_W), .WORD_W(WORD_W), .EXT_BASE(EXT_BASE), .VEC_TT(VEC_TT)
) u_chk (
  .clk(clk), .rst(rst), .vec_in(vec_in), .int_en(int_en), .irq_req(irq_req),
  .trap_idx(trap_idx), .vec_w1(vec_w1), .vec_w2(vec_w2),
  .busy_q(busy_q), .vec_prev_q(vec_prev_q)
);

// File: tb/lvl_irq_resolver_tb.sv
module lvl_irq_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {ext[59:44], soft[43:27], pil[26:23], en[22], tl[21:19], tt[18:10], req[9], idx[8:0]}
  localparam logic [59:0] TBL [NV] = '{
    {16'h0020, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h045}, // R4
    {16'h8020, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04F}, // R4
    {16'h8020, 17'h00000, 4'd15, 1'b1, 3'd0, 9'h000, 1'b0, 9'h000}, // R3
    {16'h0020, 17'h00000, 4'd5,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000}, // R3
    {16'h0040, 17'h00000, 4'd5,  1'b1, 3'd0, 9'h000, 1'b1, 9'h046}, // R3
    {16'h0000, 17'h00001, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04E}, // R2
    {16'h0000, 17'h10000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04E}, // R2 R6
    {16'h0000, 17'h00008, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h043}, // R2
    {16'h0001, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000}, // R3
    {16'h0200, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h04C, 1'b0, 9'h000}, // R5
    {16'h0200, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h048, 1'b1, 9'h049}, // R5
    {16'h0800, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h04C, 1'b1, 9'h049}, // R5
    {16'h0800, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h04C, 1'b1, 9'h04B}, // R5
    {16'h0800, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h06C, 1'b1, 9'h04B}, // R5 R6
    {16'h0800, 17'h00000, 4'd0,  1'b0, 3'd0, 9'h000, 1'b0, 9'h000}, // R7
    {16'h0800, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04B}  // R7
  };

  logic        clk = 0, rst = 1;
  logic [15:0] ext_lvl = 0;
  logic [16:0] soft_int = 0;
  logic [3:0]  cur_pil = 0;
  logic        int_en = 0;
  logic [2:0]  trap_lvl = 0;
  logic [8:0]  cur_tt = 0;
  logic        vec_in = 0;
  logic [5:0]  vec_irq = 0;
  logic        irq_req;
  logic [8:0]  trap_idx;
  logic [63:0] vec_w0, vec_w1, vec_w2;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_resolver u_dut (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int), .cur_pil(cur_pil),
    .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt), .vec_in(vec_in),
    .vec_irq(vec_irq), .irq_req(irq_req), .trap_idx(trap_idx),
    .vec_w0(vec_w0), .vec_w1(vec_w1), .vec_w2(vec_w2)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 0;
    chk("R1 req", irq_req, 0);
    chk("R1 idx", trap_idx, 0);
    chk("R1 w0", vec_w0, 0);

    for (int k = 0; k < NV; k++) begin
      ext_lvl  = TBL[k][59:44];
      soft_int = TBL[k][43:27];
      cur_pil  = TBL[k][26:23];
      int_en   = TBL[k][22];
      trap_lvl = TBL[k][21:19];
      cur_tt   = TBL[k][18:10];
      step();
      chk($sformatf("row %0d req", k), irq_req, TBL[k][9]);
      chk($sformatf("row %0d idx", k), trap_idx, TBL[k][8:0]);
    end

    // R8: vectored claim over a pending level interrupt
    vec_irq = 6'h2A; vec_in = 1;
    step();
    chk("R8 req", irq_req, 1);
    chk("R8 idx", trap_idx, 9'h060);
    chk("R8 w0", vec_w0, 64'h7EA);
    chk("R8 w1", vec_w1, 0);
    chk("R8 w2", vec_w2, 0);

    // R9: level changes while busy have no effect
    ext_lvl = 16'h8000; int_en = 0; vec_irq = 6'h01;
    step();
    chk("R9 idx", trap_idx, 9'h060);
    chk("R9 req", irq_req, 1);
    chk("R9 w0", vec_w0, 64'h7EA);
    int_en = 1;

    // R10: release drops request, keeps index, arbitration resumes after
    vec_in = 0;
    step();
    chk("R10 req", irq_req, 0);
    chk("R10 idx", trap_idx, 9'h060);
    step();
    chk("R10 resume idx", trap_idx, 9'h04F);
    chk("R10 resume req", irq_req, 1);

    // R1: reset mid-run clears, then latch is free
    rst = 1;
    step();
    rst = 0;
    chk("R1 mid req", irq_req, 0);
    chk("R1 mid idx", trap_idx, 0);
    chk("R1 mid w0", vec_w0, 0);
    vec_irq = 6'h3F; vec_in = 1;
    step();
    chk("R1 free latch idx", trap_idx, 9'h060);
    chk("R8 w0 max irq", vec_w0, 64'h7FF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule